// File: doc/BRIEF.md
# Line-State Bit-Signaling Link Controller

This block brings up a point-to-point physical link by trading a short bit vector with the peer at the far end. Each bit is carried by holding a line state: a zero is sent as Master, a one as Halt. The peer's answer in the same slot becomes the matching bit of a receive vector. A host starts the sequence, loads the number of bits and the transmit pattern, and reads back the received pattern, a state code, a break-reason code and three flags. Line-state encoding and detection are abstract two-bit codes supplied and consumed by a neighbouring coder.

The controller walks OFF, BREAK, CONNECT, NEXT and SIGNAL. A start enters BREAK and clears the bit index and the receive vector. After the minimum break time it moves to CONNECT. It then waits the minimum connect time and for the peer's Halt before reaching NEXT. From NEXT it alternates with SIGNAL once per bit until the programmed count is done, then parks in NEXT. The host may then append more bits. A signaling timeout or a lost peer forces BREAK with a reason code, and nothing leaves BREAK again until a fresh start. All dwell times count a common prescaled tick.

Top module: `bitsig_link_ctrl`

## Requirements
- R1: After reset the state code is OFF (0), the sourced line state is Quiet (0), the receive vector is zero, the reason is 0 and all flags and interrupts are low.
- R2: A start moves the state to BREAK (1) on the next clock. BREAK lasts at least the minimum break time and then goes to CONNECT (2). CONNECT goes to NEXT (3) once the minimum connect time has passed and the peer shows Halt (3).
- R3: A stop returns the state to OFF on the next clock from any state, and it takes priority over start.
- R4: In SIGNAL (4) the controller sources Master (2) for a 0 and Halt (3) for a 1. Bits go out from bit 0 upward.
- R5: A peer Halt captured in SIGNAL stores 1 and a peer Master stores 0. The value goes into the receive-vector bit at the same index as the bit being sent, and the receive vector changes only on such a capture or on a start.
- R6: After the bit at index len (len holds n-1, so n bits are exchanged, up to 16) is captured, irq_code_o pulses for one cycle and rcf_o rises. The state stays in NEXT.
- R7: Writing a larger length with new bits while parked in NEXT resumes the exchange at the next unexchanged index. Bits already received are kept.
- R8: If no valid peer Master or Halt arrives within the signaling timeout in SIGNAL, the state goes to BREAK with reason 1 and irq_break_o pulses. BREAK is then held until a new start.
- R9: Peer Quiet (0) seen in NEXT or SIGNAL forces BREAK with reason 2 and an irq_break_o pulse.
- R10: A start clears the receive vector, the bit index, the reason code and the lsf, rcf and tcf flags.
- R11: SIGNAL is not left toward NEXT before the minimum line-state transmit time has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| len_we_i | input | 1 | Write strobe for length |
| len_i | input | 4 | Bit count minus one |
| xvec_we_i | input | 1 | Write strobe for transmit vector |
| xvec_i | input | 16 | Transmit vector |
| tb_min_i | input | 16 | Minimum break time in ticks |
| c_min_i | input | 16 | Minimum connect time in ticks |
| tl_min_i | input | 16 | Minimum line-state transmit time in ticks |
| t_out_i | input | 16 | Signaling timeout in ticks |
| rx_ls_i | input | 2 | Detected peer line state: 0 Quiet, 1 Idle, 2 Master, 3 Halt |
| tx_ls_o | output | 2 | Line state to source, same encoding |
| state_o | output | 3 | State code: 0 OFF, 1 BREAK, 2 CONNECT, 3 NEXT, 4 SIGNAL |
| brk_reason_o | output | 2 | Break reason: 0 none, 1 timeout, 2 peer quiet |
| rvec_o | output | 16 | Receive vector |
| lsf_o | output | 1 | Peer line state captured for current bit |
| rcf_o | output | 1 | Receive code complete |
| tcf_o | output | 1 | Last transmit bit being sourced or done |
| irq_code_o | output | 1 | One-cycle pulse on code completion |
| irq_break_o | output | 1 | One-cycle pulse on break entry |

## Verification
The assertions assume that the host never raises start and stop together except where stop should win. They also assume that the programmed signaling timeout is longer than the minimum line-state transmit time, so that a timely peer answer always beats the timeout. The stimulus keeps within these limits. It loads length and vector a few cycles after each start, well before the minimum break ends. A peer model answers from the observed state, holds Halt in CONNECT and Idle in NEXT, and goes mute or quiet only in the cases that test timeout and line loss.

// File: rtl/bitsig_pkg.sv
package bitsig_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_BREAK   = 3'd1,
    ST_CONNECT = 3'd2,
    ST_NEXT    = 3'd3,
    ST_SIGNAL  = 3'd4
  } state_e;

  typedef enum logic [1:0] {
    LS_QUIET  = 2'd0,
    LS_IDLE   = 2'd1,
    LS_MASTER = 2'd2,
    LS_HALT   = 2'd3
  } ls_e;

  localparam logic [1:0] RSN_NONE    = 2'd0;
  localparam logic [1:0] RSN_TIMEOUT = 2'd1;
  localparam logic [1:0] RSN_QUIET   = 2'd2;
endpackage

// File: rtl/bitsig_tick_gen.sv
module bitsig_tick_gen #(
  parameter int PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bitsig_dwell_timer.sv
module bitsig_dwell_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  output logic [TMR_W-1:0] elapsed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          elapsed_o <= '0;
    else if (restart_i)                   elapsed_o <= '0;
    else if (tick_i && elapsed_o != '1)   elapsed_o <= elapsed_o + 1'b1;
  end
endmodule

// File: rtl/bitsig_vec_unit.sv
module bitsig_vec_unit #(
  parameter int VEC_MAX = 16,
  localparam int LEN_W = $clog2(VEC_MAX),
  localparam int IDX_W = LEN_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               len_we_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               xvec_we_i,
  input  logic [VEC_MAX-1:0] xvec_i,
  input  logic               capture_i,
  input  logic               peer_bit_i,
  output logic               cur_bit_o,
  output logic               pending_o,
  output logic               last_o,
  output logic [VEC_MAX-1:0] rvec_o
);
  logic [LEN_W-1:0]   len_q;
  logic [VEC_MAX-1:0] xvec_q;
  logic [IDX_W-1:0]   idx_q;

  assign pending_o = idx_q <= {1'b0, len_q};
  assign last_o    = idx_q == {1'b0, len_q};
  assign cur_bit_o = xvec_q[idx_q[LEN_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      xvec_q <= '0;
    end else begin
      if (len_we_i)  len_q  <= len_i;
      if (xvec_we_i) xvec_q <= xvec_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      rvec_o <= '0;
    end else if (clr_i) begin
      idx_q  <= '0;
      rvec_o <= '0;
    end else if (capture_i) begin
      rvec_o[idx_q[LEN_W-1:0]] <= peer_bit_i;
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/bitsig_link_ctrl.sv
module bitsig_link_ctrl
  import bitsig_pkg::*;
#(
  parameter int VEC_MAX  = 16,
  parameter int TMR_W    = 16,
  parameter int PRESCALE = 4,
  localparam int LEN_W   = $clog2(VEC_MAX)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               len_we_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               xvec_we_i,
  input  logic [VEC_MAX-1:0] xvec_i,
  input  logic [TMR_W-1:0]   tb_min_i,
  input  logic [TMR_W-1:0]   c_min_i,
  input  logic [TMR_W-1:0]   tl_min_i,
  input  logic [TMR_W-1:0]   t_out_i,
  input  logic [1:0]         rx_ls_i,
  output logic [1:0]         tx_ls_o,
  output logic [2:0]         state_o,
  output logic [1:0]         brk_reason_o,
  output logic [VEC_MAX-1:0] rvec_o,
  output logic               lsf_o,
  output logic               rcf_o,
  output logic               tcf_o,
  output logic               irq_code_o,
  output logic               irq_break_o
);
  state_e state_q, state_d;
  logic armed_q, brk, capture, code_done, restart, tick;
  logic cur_bit, pending, last;
  logic [1:0] reason_d, reason_q;
  logic [TMR_W-1:0] elapsed;
  logic peer_valid, peer_quiet, enter_sig;

  assign peer_valid = (rx_ls_i == LS_MASTER) || (rx_ls_i == LS_HALT);
  assign peer_quiet = (rx_ls_i == LS_QUIET);

  bitsig_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  bitsig_dwell_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart),
    .tick_i(tick), .elapsed_o(elapsed)
  );

  bitsig_vec_unit #(.VEC_MAX(VEC_MAX)) u_vec (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_i && !stop_i),
    .len_we_i(len_we_i), .len_i(len_i),
    .xvec_we_i(xvec_we_i), .xvec_i(xvec_i),
    .capture_i(capture), .peer_bit_i(rx_ls_i == LS_HALT),
    .cur_bit_o(cur_bit), .pending_o(pending), .last_o(last),
    .rvec_o(rvec_o)
  );

  always_comb begin
    state_d   = state_q;
    reason_d  = reason_q;
    brk       = 1'b0;
    capture   = 1'b0;
    code_done = 1'b0;
    if (stop_i) begin
      state_d = ST_OFF;
    end else if (start_i) begin
      state_d  = ST_BREAK;
      reason_d = RSN_NONE;
    end else begin
      unique case (state_q)
        ST_BREAK:
          if (armed_q && elapsed >= tb_min_i) state_d = ST_CONNECT;
        ST_CONNECT:
          if (elapsed >= c_min_i && rx_ls_i == LS_HALT) state_d = ST_NEXT;
        ST_NEXT:
          if (peer_quiet) begin
            brk = 1'b1; reason_d = RSN_QUIET;
          end else if (pending && elapsed >= tl_min_i) begin
            state_d = ST_SIGNAL;
          end
        ST_SIGNAL:
          // a valid answer wins over a simultaneous timeout
          if (elapsed >= tl_min_i && peer_valid) begin
            capture   = 1'b1;
            code_done = last;
            state_d   = ST_NEXT;
          end else if (peer_quiet) begin
            brk = 1'b1; reason_d = RSN_QUIET;
          end else if (elapsed >= t_out_i) begin
            brk = 1'b1; reason_d = RSN_TIMEOUT;
          end
        default: ;
      endcase
      if (brk) state_d = ST_BREAK;
    end
  end

  assign restart   = (state_d != state_q) || start_i;
  assign enter_sig = (state_d == ST_SIGNAL) && (state_q != ST_SIGNAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_OFF;
      reason_q    <= RSN_NONE;
      armed_q     <= 1'b0;
      irq_code_o  <= 1'b0;
      irq_break_o <= 1'b0;
      lsf_o       <= 1'b0;
      rcf_o       <= 1'b0;
      tcf_o       <= 1'b0;
    end else begin
      state_q     <= state_d;
      reason_q    <= reason_d;
      irq_code_o  <= code_done;
      irq_break_o <= brk;
      if (stop_i || brk)  armed_q <= 1'b0;
      else if (start_i)   armed_q <= 1'b1;
      if (start_i && !stop_i) begin
        lsf_o <= 1'b0; rcf_o <= 1'b0; tcf_o <= 1'b0;
      end else begin
        if (capture)        lsf_o <= 1'b1;
        else if (enter_sig) lsf_o <= 1'b0;
        if (code_done)      rcf_o <= 1'b1;
        else if (xvec_we_i) rcf_o <= 1'b0;
        if (enter_sig && last) tcf_o <= 1'b1;
        else if (xvec_we_i)    tcf_o <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_CONNECT: tx_ls_o = LS_HALT;
      ST_NEXT:    tx_ls_o = LS_IDLE;
      ST_SIGNAL:  tx_ls_o = cur_bit ? LS_HALT : LS_MASTER;
      default:    tx_ls_o = LS_QUIET;
    endcase
  end

  assign state_o      = state_q;
  assign brk_reason_o = reason_q;
endmodule

// File: rtl/bitsig_link_ctrl_chk.sv
module bitsig_link_ctrl_chk #(
  parameter int VEC_MAX = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               stop_i,
  input logic [1:0]         tx_ls_o,
  input logic [2:0]         state_o,
  input logic [1:0]         brk_reason_o,
  input logic [VEC_MAX-1:0] rvec_o,
  input logic               irq_code_o,
  input logic               irq_break_o
);
  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd0 |-> tx_ls_o == 2'd0);

  p_start_break_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i |=> state_o == 3'd1);

  p_stop_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_o == 3'd0);

  p_signal_ls_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd4 |-> tx_ls_o[1]);

  p_rvec_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 3'd4 && !start_i |=> $stable(rvec_o));

  p_code_in_next_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_code_o |-> state_o == 3'd3);

  p_break_reason_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_break_o |-> state_o == 3'd1 && brk_reason_o != 2'd0);

  p_irq_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({irq_code_o, irq_break_o}));
endmodule

bind bitsig_link_ctrl bitsig_link_ctrl_chk #(.VEC_MAX(VEC_MAX)) u_chk (.*);

// File: tb/tb_bitsig_link_ctrl.sv
module tb_bitsig_link_ctrl;
  localparam int P = 4;
  localparam int TB = 3, CM = 2, TL = 2, TO = 6;

  logic clk = 0, rst_n = 0;
  logic start = 0, stop = 0, len_we = 0, xvec_we = 0;
  logic [3:0] len = 0;
  logic [15:0] xvec = 0;
  logic [1:0] rx_ls = 0;
  logic [1:0] tx_ls, reason;
  logic [2:0] state;
  logic [15:0] rvec;
  logic lsf, rcf, tcf, irq_code, irq_break;

  int checks = 0, errors = 0;
  logic [15:0] exp_rvec_q[$];
  logic [1:0]  exp_rsn_q[$];
  logic [15:0] cur_x = 0, peer_vec = 0;
  int pk = 0, sig_cnt = 0, brk_cnt = 0;
  logic [2:0] prev_st = 0;
  bit peer_mute = 0, peer_quiet = 0, finished = 0;

  always #10 clk = ~clk;

  bitsig_link_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .len_we_i(len_we), .len_i(len), .xvec_we_i(xvec_we), .xvec_i(xvec),
    .tb_min_i(16'(TB)), .c_min_i(16'(CM)), .tl_min_i(16'(TL)), .t_out_i(16'(TO)),
    .rx_ls_i(rx_ls), .tx_ls_o(tx_ls), .state_o(state), .brk_reason_o(reason),
    .rvec_o(rvec), .lsf_o(lsf), .rcf_o(rcf), .tcf_o(tcf),
    .irq_code_o(irq_code), .irq_break_o(irq_break)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor and peer model share one process so pk is read before update
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_code) begin
        if (exp_rvec_q.size() == 0) chk(0, "R6 unexpected code irq", rvec, 0);
        else begin
          logic [15:0] e;
          e = exp_rvec_q.pop_front();
          chk(rvec == e, "R5 receive vector", rvec, e);
        end
      end
      if (irq_break) begin
        if (exp_rsn_q.size() == 0) chk(0, "R8 unexpected break irq", reason, 0);
        else begin
          logic [1:0] e;
          e = exp_rsn_q.pop_front();
          chk(reason == e, "R8/R9 break reason", reason, e);
        end
      end
      if (state == 3'd4) begin
        sig_cnt++;
        chk(tx_ls == (cur_x[pk] ? 2'd3 : 2'd2), "R4 sourced line state", tx_ls,
            cur_x[pk] ? 3 : 2);
      end
      if (state == 3'd1) brk_cnt++;
      if (prev_st == 3'd4 && state == 3'd3) begin
        chk(sig_cnt >= (TL - 1) * P, "R11 signal dwell", sig_cnt, (TL - 1) * P);
        pk++;
      end
      if (prev_st == 3'd1 && state == 3'd2)
        chk(brk_cnt >= (TB - 1) * P, "R2 break dwell", brk_cnt, (TB - 1) * P);
      if (state != 3'd4) sig_cnt = 0;
      if (state != 3'd1) brk_cnt = 0;
      if (state == 3'd1 || state == 3'd0) pk = 0;
      prev_st = state;
    end
    if (peer_quiet) rx_ls <= 2'd0;
    else case (state)
      3'd2:    rx_ls <= 2'd3;
      3'd3:    rx_ls <= 2'd1;
      3'd4:    rx_ls <= peer_mute ? 2'd1 : (peer_vec[pk] ? 2'd3 : 2'd2);
      default: rx_ls <= 2'd0;
    endcase
  end

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic load(input logic [3:0] l, input logic [15:0] x);
    @(negedge clk) begin len = l; xvec = x; len_we = 1; xvec_we = 1; cur_x = x; end
    @(negedge clk) begin len_we = 0; xvec_we = 0; end
  endtask

  task automatic wait_state(input logic [2:0] s, input string req);
    int n = 0;
    while (state != s && n < 2000) begin @(negedge clk); n++; end
    chk(state == s, req, state, s);
  endtask

  task automatic wait_code();
    int n = 0;
    while (!irq_code && n < 3000) begin @(negedge clk); n++; end
    chk(irq_code, "R6 code complete irq", irq_code, 1);
  endtask

  task automatic wait_brk();
    int n = 0;
    while (!irq_break && n < 3000) begin @(negedge clk); n++; end
    chk(irq_break, "R8 break irq", irq_break, 1);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(state == 0 && tx_ls == 0, "R1 reset state", state, 0);
    chk(rvec == 0 && reason == 0, "R1 reset vector", rvec, 0);
    chk({lsf, rcf, tcf, irq_code, irq_break} == 0, "R1 reset flags",
        {lsf, rcf, tcf, irq_code, irq_break}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 start, three bits
    pulse_start();
    chk(state == 1, "R2 start to break", state, 1);
    peer_vec = 16'h001B;
    load(4'd2, 16'h0035);
    exp_rvec_q.push_back(16'h0003);
    wait_state(3'd2, "R2 reach connect");
    wait_state(3'd3, "R2 reach next");
    wait_code();
    @(negedge clk);
    chk(rcf && tcf, "R6 flags after code", {rcf, tcf}, 3);
    chk(lsf, "R6 lsf after capture", lsf, 1);
    repeat (30) @(negedge clk);
    chk(state == 3, "R6 parks in next", state, 3);

    // R7 resume with three more bits
    exp_rvec_q.push_back(16'h001B);
    load(4'd5, 16'h0035);
    wait_code();
    @(negedge clk);
    chk(state == 3, "R7 back in next", state, 3);

    // R8 signaling timeout
    pulse_start();
    peer_mute = 1;
    load(4'd1, 16'h0002);
    exp_rsn_q.push_back(2'd1);
    wait_brk();
    peer_mute = 0;
    repeat (60) @(negedge clk);
    chk(state == 1 && tx_ls == 0, "R8 held in break", state, 1);

    // R10 start clears state left by previous run
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(reason == 0, "R10 reason cleared", reason, 0);
    chk(rvec == 0 && !rcf && !tcf && !lsf, "R10 vector and flags cleared", rvec, 0);

    // R9 peer goes quiet
    peer_vec = 16'h0005;
    load(4'd2, 16'h0002);
    wait_state(3'd3, "R9 reach next");
    exp_rsn_q.push_back(2'd2);
    peer_quiet = 1;
    wait_brk();
    peer_quiet = 0;
    chk(reason == 2, "R9 quiet reason", reason, 2);

    // R3 stop from connect and from signal
    pulse_start();
    load(4'd3, 16'h000F);
    wait_state(3'd2, "R3 reach connect");
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
    chk(state == 0, "R3 stop from connect", state, 0);
    pulse_start();
    load(4'd3, 16'h000F);
    wait_state(3'd4, "R3 reach signal");
    @(negedge clk) begin stop = 1; start = 1; end
    @(negedge clk) begin stop = 0; start = 0; end
    chk(state == 0, "R3 stop wins over start", state, 0);

    // R5 full sixteen-bit exchange
    pulse_start();
    peer_vec = 16'h3C96;
    load(4'd15, 16'hA5C3);
    exp_rvec_q.push_back(16'h3C96);
    wait_code();
    @(negedge clk);
    chk(rvec == 16'h3C96, "R5 full vector", rvec, 16'h3C96);

    repeat (10) @(negedge clk);
    chk(exp_rvec_q.size() == 0 && exp_rsn_q.size() == 0, "R6 scoreboard drained",
        exp_rvec_q.size() + exp_rsn_q.size(), 0);
    finished = 1;
    finish_run();
  end
endmodule